// File: doc/BRIEF.md
# Bus-Master DMA Register Block

This block holds the per-channel bus-master registers of a two-channel disk controller. Each channel has a command byte, a status byte and a 32-bit descriptor-table pointer. A host reaches them through a byte-addressed register port with 1, 2 or 4-byte accesses. The block applies each register's write rules. When a transfer is started or stopped, it sends a one-cycle start or abort pulse to the DMA engine of the drive selected on that channel. It also takes completion and fault indications from the engines and raises a per-channel interrupt flag.

Each channel owns an 8-byte slice of a 16-byte window. Channel 0 uses bytes 0 to 7 and channel 1 uses bytes 8 to 15. Within a slice, offset 0 is the command byte, offset 2 is the status byte and offsets 4 to 7 hold the pointer, little-endian. Offsets 1 and 3 are plain scratch bytes. `reg_size` codes the access width: 0 is one byte, 1 is two bytes, 2 is four bytes, and 3 is handled as four bytes. The command byte uses bit 0 for run (start/stop) and bit 3 for direction. The status byte uses bit 0 for active, bit 1 for fault, bit 2 for interrupt, bit 5 for drive 0 DMA-capable and bit 6 for drive 1 DMA-capable. Drive `d` of channel `c` is index `2*c+d` of `dma_start` and `dma_abort`.

Top module: `bm_dma_regs`

## Requirements
- R1: After reset both status bytes read 0x60, every other byte of the window reads 0, and `irq`, `dma_start`, `dma_abort` and `size_err` are 0.
- R2: While `bus_master_en` is low, a write changes no register and produces no start pulse, abort pulse or `size_err`.
- R3: A write to offset 0 or offset 2 with a size other than one byte, or to offset 4 with a size code other than 2, changes nothing and pulses `size_err` for one cycle on the next clock.
- R4: While run (command bit 0) is 1, a command write keeps the stored direction bit (bit 3) and ignores the written value.
- R5: A command write that takes run from 0 to 1 sets status bit 0. On the next clock it pulses `dma_start[2c+drive_sel[c]]` for one cycle.
- R6: A command write that takes run from 1 to 0 clears status bit 0. On the next clock it pulses `dma_abort[2c+drive_sel[c]]` for one cycle.
- R7: Status bit 0 ignores host writes. Status bits 1 and 2 clear only when a 1 is written while they are set; otherwise they keep their value. Status bits 7..3 take the written value.
- R8: A pointer write stores the data with bits 1..0 forced to 0. `dma_ptr[32c+:32]` shows channel c's pointer.
- R9: `dma_done[c]` clears run and status bit 0 and sets status bit 2, and `irq[c]` follows status bit 2. `dma_done[c]` overrides a same-cycle host write for those bits and suppresses that cycle's start or abort pulse on channel c.
- R10: A write starting at any other offset stores into scratch bytes (offsets 1 and 3 of either channel) only. Bytes that land on another register or past the window are dropped.
- R11: `reg_rdata` returns the 1, 2 or 4 bytes from `reg_addr` upward, little-endian. Unused upper bytes and bytes past the window read 0.
- R12: `dma_err[c]` sets status bit 1 of channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_master_en | input | 1 | Enables register writes |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 4 | Byte address in the window |
| reg_size | input | 2 | Access size code |
| reg_wdata | input | 32 | Write data, byte 0 in bits 7..0 |
| reg_rdata | output | 32 | Read data |
| size_err | output | 1 | Illegal-size write flag |
| drive_sel | input | 2 | Selected drive per channel |
| dma_start | output | 4 | Start pulse per drive |
| dma_abort | output | 4 | Abort pulse per drive |
| dma_ptr | output | 64 | Descriptor pointer per channel |
| dma_done | input | 2 | Completion per channel |
| dma_err | input | 2 | Fault per channel |
| irq | output | 2 | Interrupt flag per channel |

## Verification
The bench targets several corner cases.

- A direction change attempted mid-transfer, and the stop that follows. A design that unlocks direction too early would store the new direction on the stop write.
- A status write of 0 over a pending interrupt. A design that copies status writes naively would drop the interrupt or set the active bit.
- A completion that lands in the same cycle as a stop or a status clear. A design with the wrong priority would emit a stray abort or lose the interrupt.
- Unaligned multi-byte writes that span registers or run past the window. These must touch only scratch bytes and never start a transfer.

// File: rtl/bm_dma_regs.sv
module bm_dma_regs #(
  parameter int NCH = 2,
  localparam int AW = $clog2(NCH * 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_master_en,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [1:0]        reg_size,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              size_err,
  input  logic [NCH-1:0]    drive_sel,
  output logic [2*NCH-1:0]  dma_start,
  output logic [2*NCH-1:0]  dma_abort,
  output logic [32*NCH-1:0] dma_ptr,
  input  logic [NCH-1:0]    dma_done,
  input  logic [NCH-1:0]    dma_err,
  output logic [NCH-1:0]    irq
);
  localparam int WB = NCH * 8;

  wire wr_ok = reg_wr && bus_master_en;
  wire sz_b  = reg_size == 2'd0;
  wire sz_w  = reg_size == 2'd2;
  wire plain_wr = wr_ok && !(reg_addr[2:0] inside {3'd0, 3'd2, 3'd4});
  logic [2:0] nbytes;
  assign nbytes = sz_b ? 3'd1 : (reg_size == 2'd1 ? 3'd2 : 3'd4);

  logic [WB*8-1:0] win;
  logic [NCH-1:0]  err_c, ss_v, dir_v, act_v;
  logic            err_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] BASE = AW'(c * 8);
    logic [7:0]  cmd_q, sts_q, cmd_n, sts_n;
    logic [31:0] ptr_q;
    logic [7:0]  pad_q [2];
    logic [7:0]  pad_d [2];
    logic [1:0]  st_q, ab_q;

    wire hit_cmd = wr_ok && reg_addr == BASE;
    wire hit_sts = wr_ok && reg_addr == BASE + AW'(2);
    wire hit_ptr = wr_ok && reg_addr == BASE + AW'(4);
    wire cmd_go  = hit_cmd && sz_b;

    always_comb begin
      cmd_n = reg_wdata[7:0];
      if (cmd_q[0]) cmd_n[3] = cmd_q[3];
    end

    wire rise = cmd_go && !cmd_q[0] && cmd_n[0] && !dma_done[c];
    wire fall = cmd_go && cmd_q[0] && !cmd_n[0] && !dma_done[c];
    assign err_c[c] = ((hit_cmd || hit_sts) && !sz_b) || (hit_ptr && !sz_w);

    always_comb begin
      sts_n = sts_q;
      if (hit_sts && sz_b)
        sts_n = {reg_wdata[7:3], sts_q[2] & ~reg_wdata[2], sts_q[1] & ~reg_wdata[1], sts_q[0]};
      if (rise) sts_n[0] = 1'b1;
      if (fall) sts_n[0] = 1'b0;
      if (dma_err[c]) sts_n[1] = 1'b1;
      if (dma_done[c]) begin
        sts_n[0] = 1'b0;
        sts_n[2] = 1'b1;
      end
    end

    always_comb begin
      pad_d[0] = pad_q[0];
      pad_d[1] = pad_q[1];
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 2; k++)
          if (plain_wr && j < int'(nbytes) &&
              ({1'b0, reg_addr} + (AW+1)'(j)) == (AW+1)'(c * 8 + 2 * k + 1))
            pad_d[k] = reg_wdata[8*j +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmd_q <= '0;
        sts_q <= 8'h60;
        ptr_q <= '0;
        pad_q[0] <= '0;
        pad_q[1] <= '0;
        st_q <= '0;
        ab_q <= '0;
      end else begin
        if (cmd_go) cmd_q <= cmd_n;
        if (dma_done[c]) cmd_q[0] <= 1'b0;
        sts_q <= sts_n;
        if (hit_ptr && sz_w) ptr_q <= {reg_wdata[31:2], 2'b00};
        pad_q[0] <= pad_d[0];
        pad_q[1] <= pad_d[1];
        st_q <= rise ? (drive_sel[c] ? 2'b10 : 2'b01) : 2'b00;
        ab_q <= fall ? (drive_sel[c] ? 2'b10 : 2'b01) : 2'b00;
      end
    end

    assign win[c*64 +: 64]   = {ptr_q, pad_q[1], sts_q, pad_q[0], cmd_q};
    assign dma_start[2*c +: 2] = st_q;
    assign dma_abort[2*c +: 2] = ab_q;
    assign dma_ptr[32*c +: 32] = ptr_q;
    assign irq[c]   = sts_q[2];
    assign ss_v[c]  = cmd_q[0];
    assign dir_v[c] = cmd_q[3];
    assign act_v[c] = sts_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= |err_c;
  end
  assign size_err = err_q;

  logic [WB*8+31:0] wext;
  assign wext = {32'b0, win} >> {reg_addr, 3'b000};
  assign reg_rdata = sz_b ? {24'b0, wext[7:0]} :
                     (reg_size == 2'd1) ? {16'b0, wext[15:0]} : wext[31:0];
endmodule

// File: rtl/bm_dma_regs_chk.sv
module bm_dma_regs_chk #(
  parameter int NCH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_master_en,
  input logic             reg_wr,
  input logic             size_err,
  input logic [NCH-1:0]   dma_done,
  input logic [NCH-1:0]   irq,
  input logic [2*NCH-1:0] dma_start,
  input logic [2*NCH-1:0] dma_abort,
  input logic [NCH-1:0]   ss_v,
  input logic [NCH-1:0]   dir_v,
  input logic [NCH-1:0]   act_v
);
  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !bus_master_en) |=> (dma_start == '0 && dma_abort == '0 && !size_err));

  a_r5_one_command: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_start, dma_abort}));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    a_r4_dir_locked: assert property (@(posedge clk) disable iff (!rst_n)
      ss_v[c] |=> dir_v[c] == $past(dir_v[c]));

    a_r5_active_with_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_v[c]) |-> dma_start[2*c +: 2] != 2'b00);

    a_r9_done_effect: assert property (@(posedge clk) disable iff (!rst_n)
      dma_done[c] |=> (!ss_v[c] && !act_v[c] && irq[c]));

    a_r9_no_cmd_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      dma_done[c] |=> (dma_start[2*c +: 2] == 2'b00 && dma_abort[2*c +: 2] == 2'b00));
  end
endmodule

bind bm_dma_regs bm_dma_regs_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_master_en(bus_master_en), .reg_wr(reg_wr),
  .size_err(size_err), .dma_done(dma_done), .irq(irq), .dma_start(dma_start),
  .dma_abort(dma_abort), .ss_v(ss_v), .dir_v(dir_v), .act_v(act_v)
);

// File: tb/bm_dma_regs_test.sv
module bm_dma_regs_test;
  logic clk = 0, rst_n = 0, bmen = 0, wr = 0;
  logic [3:0] addr = 0;
  logic [1:0] sz = 0, dsel = 0, done = 0, derr = 0;
  logic [31:0] wdata = 0, rdata;
  logic serr;
  logic [3:0] st, ab;
  logic [63:0] ptr;
  logic [1:0] irq;
  int total = 0, bad = 0;
  bit running = 0;

  always #2 clk = ~clk;

  bm_dma_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_master_en(bmen), .reg_wr(wr), .reg_addr(addr),
    .reg_size(sz), .reg_wdata(wdata), .reg_rdata(rdata), .size_err(serr),
    .drive_sel(dsel), .dma_start(st), .dma_abort(ab), .dma_ptr(ptr),
    .dma_done(done), .dma_err(derr), .irq(irq)
  );

  logic [7:0] mb [16];
  logic [3:0] e_st, e_ab;
  logic e_err;
  int ch, off, n, a, b;
  logic [7:0] o, nv;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mb[i] = 8'h00;
      mb[2] = 8'h60; mb[10] = 8'h60;
      e_st = 0; e_ab = 0; e_err = 0;
    end else begin
      e_st = 0; e_ab = 0; e_err = 0;
      if (wr && bmen) begin
        ch = addr / 8; off = addr % 8; b = ch * 8;
        n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        if (off == 0) begin
          if (sz != 0) e_err = 1;
          else begin
            o = mb[b]; nv = wdata[7:0];
            if (o[0]) nv[3] = o[3];
            if (!done[ch]) begin
              if (!o[0] && nv[0]) begin mb[b+2][0] = 1'b1; e_st[ch*2+dsel[ch]] = 1'b1; end
              if (o[0] && !nv[0]) begin mb[b+2][0] = 1'b0; e_ab[ch*2+dsel[ch]] = 1'b1; end
            end
            mb[b] = nv;
          end
        end else if (off == 2) begin
          if (sz != 0) e_err = 1;
          else begin
            o = mb[b+2]; nv = wdata[7:0];
            nv[0] = o[0];
            nv[1] = o[1] & ~wdata[1];
            nv[2] = o[2] & ~wdata[2];
            mb[b+2] = nv;
          end
        end else if (off == 4) begin
          if (sz != 2) e_err = 1;
          else {mb[b+7], mb[b+6], mb[b+5], mb[b+4]} = {wdata[31:2], 2'b00};
        end else begin
          for (int j = 0; j < n; j++) begin
            a = addr + j;
            if (a < 16 && (a % 8 == 1 || a % 8 == 3)) mb[a] = wdata[8*j +: 8];
          end
        end
      end
      for (int c = 0; c < 2; c++) begin
        if (derr[c]) mb[c*8+2][1] = 1'b1;
        if (done[c]) begin mb[c*8][0] = 1'b0; mb[c*8+2][0] = 1'b0; mb[c*8+2][2] = 1'b1; end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && running) begin
    chk("R5 start pulse", 64'(st), 64'(e_st));
    chk("R6 abort pulse", 64'(ab), 64'(e_ab));
    chk("R3 size_err", 64'(serr), 64'(e_err));
    chk("R9 irq", 64'(irq), 64'({mb[10][2], mb[2][2]}));
    chk("R8 pointer out", ptr, {mb[15], mb[14], mb[13], mb[12], mb[7], mb[6], mb[5], mb[4]});
  end

  task automatic op(input logic w, input int ad, input int s, input logic [31:0] d,
                    input logic [1:0] dn, input logic [1:0] de);
    @(negedge clk);
    wr = w; addr = 4'(ad); sz = 2'(s); wdata = d; done = dn; derr = de;
    @(negedge clk);
    wr = 0; done = 0; derr = 0;
  endtask

  task automatic rchk(input int ad, input int s, input string tag);
    logic [31:0] e;
    int nn;
    @(negedge clk);
    wr = 0; addr = 4'(ad); sz = 2'(s);
    #1;
    e = 0;
    nn = (s == 0) ? 1 : (s == 1) ? 2 : 4;
    for (int j = 0; j < nn; j++) if (ad + j < 16) e[8*j +: 8] = mb[ad + j];
    chk(tag, 64'(rdata), 64'(e));
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog got=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    running = 1;
    rchk(2, 0, "R1 status0 reset");
    rchk(10, 0, "R1 status1 reset");
    rchk(0, 2, "R1 ch0 low word");
    rchk(4, 2, "R1 ch0 pointer");
    rchk(12, 2, "R1 ch1 pointer");

    op(1, 0, 0, 32'h01, 0, 0);
    op(1, 4, 2, 32'hFFFF_FFFF, 0, 0);
    rchk(0, 0, "R2 cmd unchanged");
    rchk(2, 0, "R2 status unchanged");
    rchk(4, 2, "R2 pointer unchanged");

    bmen = 1;
    op(1, 4, 2, 32'h1234_567B, 0, 0);
    rchk(4, 2, "R8 pointer low bits");
    op(1, 0, 1, 32'h0101, 0, 0);
    rchk(0, 0, "R3 cmd wrong size");
    op(1, 4, 0, 32'h55, 0, 0);
    rchk(4, 2, "R3 pointer wrong size");
    op(1, 2, 2, 32'h0, 0, 0);
    rchk(2, 0, "R3 status wrong size");

    dsel = 2'b01;
    op(1, 0, 0, 32'h09, 0, 0);
    rchk(2, 0, "R5 active set");
    op(1, 0, 0, 32'h01, 0, 0);
    rchk(0, 0, "R4 dir held");
    op(1, 0, 0, 32'h00, 0, 0);
    rchk(2, 0, "R6 active cleared");
    rchk(0, 0, "R4 dir held on stop");
    op(1, 0, 0, 32'h01, 0, 0);
    op(0, 0, 0, 0, 2'b01, 0);
    rchk(0, 0, "R9 run cleared");
    rchk(2, 0, "R9 irq status");

    op(1, 2, 0, 32'h61, 0, 0);
    rchk(2, 0, "R7 zero write keeps irq");
    op(1, 2, 0, 32'h05, 0, 0);
    rchk(2, 0, "R7 w1c irq, active read-only");
    op(0, 0, 0, 0, 0, 2'b01);
    rchk(2, 0, "R12 fault set");
    op(1, 2, 0, 32'h02, 0, 0);
    rchk(2, 0, "R7 w1c fault");

    op(1, 8, 0, 32'h01, 0, 0);
    op(1, 8, 0, 32'h00, 2'b10, 0);
    rchk(10, 0, "R9 done beats stop");
    op(1, 10, 0, 32'h04, 2'b10, 0);
    rchk(10, 0, "R9 done beats irq clear");
    op(1, 8, 0, 32'h01, 2'b10, 0);
    rchk(8, 0, "R9 done beats start");

    op(1, 1, 0, 32'hAB, 0, 0);
    op(1, 7, 2, 32'hDDCC_BBAA, 0, 0);
    op(1, 13, 2, 32'h1234_5678, 0, 0);
    op(1, 15, 1, 32'h1111, 0, 0);
    op(1, 3, 1, 32'h7766, 0, 0);
    rchk(0, 2, "R10 ch0 scratch");
    rchk(8, 2, "R10 ch1 scratch");
    rchk(4, 2, "R10 pointer untouched");
    rchk(14, 2, "R11 read past window");
    rchk(1, 1, "R11 two-byte read");
    rchk(3, 0, "R11 one-byte read");

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      bmen = ($urandom % 10) != 0;
      dsel = 2'($urandom);
      wr = ($urandom % 3) != 0;
      addr = 4'($urandom);
      sz = 2'($urandom % 3);
      wdata = $urandom;
      done = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      derr = (($urandom % 16) == 0) ? 2'($urandom) : 2'b00;
      if (i % 5 == 4) begin
        wr = 0; done = 0; derr = 0;
        #1;
        begin
          logic [31:0] e;
          int nn;
          e = 0;
          nn = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
          for (int j = 0; j < nn; j++) if (addr + j < 16) e[8*j +: 8] = mb[addr + j];
          chk("R11 random read", 64'(rdata), 64'(e));
        end
      end
    end
    @(negedge clk);
    wr = 0; done = 0; derr = 0;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule